// File: doc/BRIEF.md
# Universal Latched/Registered Bus Transceiver

This block is a non-inverting, two-way bus transceiver between an A port and a B port, 18 bits wide by default. Each direction (A-to-B and B-to-A) has its own storage element. A latch-enable input switches that element between a transparent latch and a rising-edge register. The register mode is gated by an active-low clock enable. An active-low output enable selects whether that direction drives its destination port or leaves it at high impedance. Each output is a data-plus-enable pair. When the enable is low the data lines read as zero, and the surrounding logic treats the pair as an undriven bus.

The block runs on one system clock with a synchronous active-high reset. The per-direction bus clocks are sampled on that clock, and a low-to-high transition seen between two samples counts as a capture edge. Every storage and output-enable update appears at the ports one system-clock cycle after its inputs are sampled.

Each port has a bit-wise bus keeper. For each bit the keeper resolves the port from three sources, in this priority: the external driver, when that bit's input-enable is high; otherwise the block's own opposite-direction output, when that output is enabled; otherwise the level the keeper holds. The resolved value feeds the storage of the other direction.

Enabling both output enables at the same time is a usage error. Each direction then feeds the other through the keepers, and the result is a loop with no defined owner. The block does not guard against this case.

Top module: `univ_bus_xcvr`

## Requirements
- R1: With the latch enable high, the opposite port's output data equals the resolved source port one cycle later, whatever the bus clock and clock enable are doing.
- R2: With the latch enable low and the clock enable low, a low-to-high transition of the bus clock stores the resolved source port. The stored value appears one cycle after the sample in which the clock is first seen high.
- R3: With the latch enable low and the bus clock held steady high or steady low, the stored value does not change.
- R4: With the latch enable low and the clock enable high, bus clock edges are ignored and the stored value does not change.
- R5: With the output enable high, the direction's output-enable port is 0 and its data reads 0 one cycle later. With the output enable low, the output-enable port is 1 and the data shows the stored value.
- R6: The B-to-A direction follows R1 to R5 using its own four controls, independently of the A-to-B controls.
- R7: The path is non-inverting and bit-parallel: bit i of the output comes from bit i of the source, for all-zero, all-one and mixed patterns.
- R8: A source bit whose input-enable is 0, and which is not driven by the block's own output, keeps its last resolved level. A direction that reads that bit transparently therefore keeps outputting the old level.
- R9: When the latch enable falls, the storage keeps the last value passed through transparently until a qualifying clock edge occurs.
- R10: During and right after reset, both output enables are 0, both data outputs are 0, and stored values and keeper levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | External data on the A port |
| a_in_en | input | W | Per-bit flag: external driver active on the A port |
| a_out | output | W | Data driven onto the A port (B-to-A path) |
| a_out_en | output | 1 | A port drive enable |
| b_in | input | W | External data on the B port |
| b_in_en | input | W | Per-bit flag: external driver active on the B port |
| b_out | output | W | Data driven onto the B port (A-to-B path) |
| b_out_en | output | 1 | B port drive enable |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B bus clock |
| ab_clk_en_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A bus clock |
| ba_clk_en_n | input | 1 | B-to-A clock enable, active low |

## Verification
A wrong stored value shows on the output data one cycle after the faulty update, but only while that direction's output enable is low. The bench therefore keeps the output enabled during the latch, clock and hold steps, and turns it off only to check the high-impedance row. A missed or spurious clock edge shows as the output either keeping the old word or taking the new one in the cycle after the bus clock rises. A keeper that loses its level shows one cycle after the external driver is released, through a transparent direction reading that bit.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W_DEF = 18;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic bclk;
    logic bclk_en_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = xcvr_pkg::XCVR_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ext_dat,
  input  logic [W-1:0] ext_en,
  input  logic [W-1:0] own_dat,
  input  logic         own_en,
  output logic [W-1:0] res_dat
);
  logic [W-1:0] keep_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (ext_en[i])   res_dat[i] = ext_dat[i];
      else if (own_en) res_dat[i] = own_dat[i];
      else             res_dat[i] = keep_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) keep_q[i] <= 1'b0;
      else     keep_q[i] <= res_dat[i];
    end

    // R8: an undriven bit keeps its previous resolved level
    a_r8_keeper_holds: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !ext_en[i] && !own_en) |-> (res_dat[i] == $past(res_dat[i])));
  end
endmodule

// File: rtl/xcvr_dir_store.sv
module xcvr_dir_store #(
  parameter int W = xcvr_pkg::XCVR_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       din,
  input  xcvr_pkg::dir_ctl_t ctl,
  output logic [W-1:0]       dout,
  output logic               dout_en
);
  logic         bclk_q;
  logic         bclk_rise;
  logic         capture;
  logic [W-1:0] store_q;
  logic         en_q;

  assign bclk_rise = ctl.bclk & ~bclk_q;
  assign capture   = ctl.le | (~ctl.bclk_en_n & bclk_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      store_q <= '0;
      en_q    <= 1'b0;
    end else begin
      bclk_q <= ctl.bclk;
      en_q   <= ~ctl.oe_n;
      if (capture) store_q <= din;
    end
  end

  assign dout    = en_q ? store_q : '0;
  assign dout_en = en_q;

  // R1: transparent mode passes the input after one cycle
  a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ctl.le)) |-> (store_q == $past(din)));

  // R4: with the clock enable inactive, storage holds
  a_r4_gated_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!ctl.le && ctl.bclk_en_n)) |-> $stable(store_q));

  // R3: a steady bus clock in latch-closed mode holds storage
  a_r3_steady_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2) && $past(!ctl.le) &&
     ($past(ctl.bclk) == $past(ctl.bclk, 2))) |-> $stable(store_q));

  // R5: a high output enable leaves the port undriven next cycle
  a_r5_disable: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.oe_n) |-> (!dout_en && dout == '0));
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr #(
  parameter int W = xcvr_pkg::XCVR_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_in_en,
  output logic [W-1:0] a_out,
  output logic         a_out_en,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_in_en,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_clk_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_clk_en_n
);
  import xcvr_pkg::*;

  localparam int NDIR = 2;

  dir_ctl_t     ctl   [NDIR];
  logic [W-1:0] src   [NDIR];
  logic [W-1:0] dst   [NDIR];
  logic         dst_en[NDIR];
  logic [W-1:0] a_res, b_res;

  assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, bclk: ab_clk, bclk_en_n: ab_clk_en_n};
  assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, bclk: ba_clk, bclk_en_n: ba_clk_en_n};
  assign src[0] = a_res;
  assign src[1] = b_res;

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst(rst), .ext_dat(a_in), .ext_en(a_in_en),
    .own_dat(a_out), .own_en(a_out_en), .res_dat(a_res));

  xcvr_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst(rst), .ext_dat(b_in), .ext_en(b_in_en),
    .own_dat(b_out), .own_en(b_out_en), .res_dat(b_res));

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_dir_store #(.W(W)) u_store (
      .clk(clk), .rst(rst), .din(src[d]), .ctl(ctl[d]),
      .dout(dst[d]), .dout_en(dst_en[d]));
  end

  assign b_out    = dst[0];
  assign b_out_en = dst_en[0];
  assign a_out    = dst[1];
  assign a_out_en = dst_en[1];

  // R10: nothing is driven right after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!a_out_en && !b_out_en && a_out == '0 && b_out == '0));
endmodule

// File: tb/univ_bus_xcvr_tb.sv
`timescale 1ns/1ps
module univ_bus_xcvr_tb;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = '0, a_in_en = '1, b_in = '0, b_in_en = '1;
  logic [W-1:0] a_out, b_out;
  logic a_out_en, b_out_en;
  logic ab_oe_n = 1, ab_le = 0, ab_clk = 0, ab_clk_en_n = 1;
  logic ba_oe_n = 1, ba_le = 0, ba_clk = 0, ba_clk_en_n = 1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  univ_bus_xcvr #(.W(W)) u_dut (.*);

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp, logic aen, logic een);
    checks++;
    if (act !== exp || aen !== een) begin
      errors++;
      $display("FAIL %s: actual data %h en %b, expected data %h en %b", tag, act, aen, exp, een);
    end
  endtask

  task automatic t_reset();
    rst = 1; step(2);
    chk("R10 b during reset", b_out, '0, b_out_en, 0);
    chk("R10 a during reset", a_out, '0, a_out_en, 0);
    rst = 0; ab_oe_n = 0; ba_oe_n = 0; step();
    chk("R10 b stored zero", b_out, '0, b_out_en, 1);
    chk("R10 a stored zero", a_out, '0, a_out_en, 1);
    ba_oe_n = 1; step();
  endtask

  task automatic t_transparent();
    logic [W-1:0] pat [4] = '{18'h2A5C3, 18'h00000, 18'h3FFFF, 18'h15555};
    ab_le = 1; ab_clk_en_n = 0;
    foreach (pat[i]) begin
      a_in = pat[i]; ab_clk = ~ab_clk; step();
      chk("R1/R7 transparent A-to-B", b_out, pat[i], b_out_en, 1);
    end
    ab_clk_en_n = 1; a_in = 18'h0F0F0; ab_clk = ~ab_clk; step();
    chk("R1 transparent with clock disabled", b_out, 18'h0F0F0, b_out_en, 1);
  endtask

  task automatic t_latch_fall();
    ab_le = 1; ab_clk = 0; a_in = 18'h1A2B3; step();
    ab_le = 0; ab_clk_en_n = 0; a_in = 18'h3C3C3; step(2);
    chk("R9 latch fall keeps last value", b_out, 18'h1A2B3, b_out_en, 1);
  endtask

  task automatic t_clocked();
    ab_le = 0; ab_clk_en_n = 0; ab_clk = 0; a_in = 18'h2468A; step();
    chk("R3 steady low clock holds", b_out, 18'h1A2B3, b_out_en, 1);
    ab_clk = 1; step();
    chk("R2 rising edge captures", b_out, 18'h2468A, b_out_en, 1);
    a_in = 18'h13579; step(2);
    chk("R3 steady high clock holds", b_out, 18'h2468A, b_out_en, 1);
    ab_clk = 0; step();
    chk("R3 falling edge ignored", b_out, 18'h2468A, b_out_en, 1);
    ab_clk = 1; step();
    chk("R2 second rising edge captures", b_out, 18'h13579, b_out_en, 1);
  endtask

  task automatic t_clk_gated();
    ab_clk_en_n = 1; ab_clk = 0; a_in = 18'h0ABCD; step();
    ab_clk = 1; step(); ab_clk = 0; step(); ab_clk = 1; step();
    chk("R4 edges ignored with clock enable high", b_out, 18'h13579, b_out_en, 1);
  endtask

  task automatic t_disable();
    ab_oe_n = 1; step();
    chk("R5 A-to-B high impedance", b_out, '0, b_out_en, 0);
    ab_le = 1; a_in = 18'h33333; step();
    chk("R5 disabled overrides transparent", b_out, '0, b_out_en, 0);
    ab_oe_n = 0; step();
    chk("R5 re-enabled shows stored", b_out, 18'h33333, b_out_en, 1);
  endtask

  task automatic t_b_to_a();
    ab_oe_n = 1; ab_le = 0; ab_clk_en_n = 1;
    ba_oe_n = 0; ba_le = 1; b_in = 18'h1C71C; step();
    chk("R6 B-to-A transparent", a_out, 18'h1C71C, a_out_en, 1);
    chk("R6 A-to-B stays off", b_out, '0, b_out_en, 0);
    ba_le = 0; ba_clk_en_n = 0; ba_clk = 0; b_in = 18'h2E38E; step();
    chk("R6 B-to-A latch closed holds", a_out, 18'h1C71C, a_out_en, 1);
    ba_clk = 1; step();
    chk("R6 B-to-A rising edge captures", a_out, 18'h2E38E, a_out_en, 1);
    ba_clk_en_n = 1; ba_clk = 0; b_in = 18'h00FFF; step(); ba_clk = 1; step();
    chk("R6 B-to-A gated clock ignored", a_out, 18'h2E38E, a_out_en, 1);
    ba_oe_n = 1; step();
    chk("R6 B-to-A high impedance", a_out, '0, a_out_en, 0);
  endtask

  task automatic t_keeper();
    logic [W-1:0] v_old = 18'h2D2B4, v_new = 18'h05A5A, mask = 18'h001FF;
    ba_oe_n = 1; ab_oe_n = 0; ab_le = 1; a_in_en = ONES; a_in = v_old; step();
    a_in_en = '0; a_in = ~v_old; step(2);
    chk("R8 released bus keeps level", b_out, v_old, b_out_en, 1);
    a_in_en = mask; a_in = v_new; step();
    chk("R8 partial release per bit", b_out, (v_old & ~mask) | (v_new & mask), b_out_en, 1);
    a_in_en = ONES;
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_latch_fall();
    t_clocked();
    t_clk_gated();
    t_disable();
    t_b_to_a();
    t_keeper();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule